// File: doc/BRIEF.md
# Process-Selective TLB Flush Walker

This block clears the translation entries that belong to one address-space owner. A request presents an 8-bit process tag. The walker then visits every slot of two translation buffers (instruction and data), each organised as 4 sets of 16 slots. It reads each slot through a synchronous port to the entry storage and tests the slot against the request. For each slot that must go, it emits a single-cycle flush pulse. The pulse carries the page-aligned virtual address held in that slot and the slot's buffer, set and index. When the last slot has been judged, a single-cycle completion pulse follows.

Each slot is a pair of 32-bit words. The tag word holds the virtual page number in bits 31..13 and the owner tag in bits 7..0. The attribute word holds a valid flag in bit 3 and a shared (global) flag in bit 4. Slots marked shared are never removed, because they belong to every process.

The control path is a five-state machine. ST_IDLE waits for a request. ST_SCAN issues one storage read per cycle. ST_WAIT covers the storage latency of the last read. ST_TAIL covers the registered flush decision for the last slot. ST_DONE raises the completion pulse. The transitions are: ST_IDLE to ST_SCAN on a request; ST_SCAN to itself until the final slot address has been issued, then to ST_WAIT; ST_WAIT to ST_TAIL; ST_TAIL to ST_DONE; ST_DONE to ST_IDLE. The buffer, set and slot counts must be powers of two, each at least 2.

Top module: `tlbf_scanner`

## Requirements
- R1: While reset is held, and in the cycle after it is released, busy_o, done_o, rd_en_o and flush_o are all low.
- R2: A start_i sampled high while the walker is idle (busy_o and done_o both low) captures pid_i. From the next cycle, busy_o is high and rd_en_o is high with slot address 0.
- R3: The walker issues exactly 128 reads, one per cycle, with no gaps. The slot address is {rd_tlb_o, rd_set_o, rd_idx_o}, and it counts up from 0 to 127, so the buffer number changes slowest and the slot index fastest.
- R4: Storage returns the tag and attribute words on the cycle after a read is issued. The flush decision for the slot read in cycle c appears on the flush outputs in cycle c+2.
- R5: A slot is flushed when all three of these hold: attribute bit 3 (valid) is 1, attribute bit 4 (shared) is 0, and tag bits 7..0 equal the captured process tag.
- R6: A flush pulse lasts one cycle. flush_addr_o equals tag bits 31..13 followed by 13 zero bits. flush_tlb_o, flush_set_o and flush_idx_o identify the slot.
- R7: A slot that is shared, invalid or owned by another process produces no flush pulse.
- R8: With the request sampled at edge E0, busy_o is high in the 130 cycles after E0. done_o is high for exactly one cycle, the 131st, and busy_o is low in that cycle.
- R9: start_i is ignored while busy_o or done_o is high. A change of pid_i after the request is captured has no effect on the walk.
- R10: After the completion pulse, the walker returns to idle and accepts a new request with a new process tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a walk |
| pid_i | input | 8 | Process tag to remove |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_en_o | output | 1 | Storage read request |
| rd_tlb_o | output | 1 | Read address: buffer (0 instruction, 1 data) |
| rd_set_o | output | 2 | Read address: set |
| rd_idx_o | output | 4 | Read address: slot index |
| rd_hi_i | input | 32 | Tag word, valid the cycle after the read |
| rd_lo_i | input | 32 | Attribute word, valid the cycle after the read |
| flush_o | output | 1 | One-cycle flush pulse |
| flush_addr_o | output | 32 | Page-aligned virtual address to invalidate |
| flush_tlb_o | output | 1 | Buffer of the flushed slot |
| flush_set_o | output | 2 | Set of the flushed slot |
| flush_idx_o | output | 4 | Index of the flushed slot |

## Verification
The assertions take as given that the storage answers each read one cycle later and never stalls. The bench's storage model is a registered array read on every rd_en_o, so this assumption always holds. The assertions also take as given that start_i may arrive at any time. The bench therefore deliberately raises start_i, with a different tag, in the middle of a walk and again during the completion cycle, so the restart-protection properties are exercised rather than avoided. Slot contents are generated from several seeds and fill modes: mixed, all-matching, all-shared and all-invalid. These cover both the first and last slot as matches, as well as walks that produce no flush at all.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_WAIT,
        ST_TAIL,
        ST_DONE
    } scan_state_e;

    // Attribute-word flag positions (decoded by the translation logic as well)
    localparam int LO_VALID_BIT  = 3;
    localparam int LO_GLOBAL_BIT = 4;
    // Tag-word layout
    localparam int HI_VPN_LSB    = 13;

endpackage

// File: rtl/tlbf_walker.sv
module tlbf_walker
    import tlbf_pkg::*;
#(
    parameter int ENTRIES = 128,
    parameter int CNT_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             rd_en_o,
    output logic             load_o,
    output logic [CNT_W-1:0] rd_ptr_o
);

    localparam logic [CNT_W-1:0] LAST_PTR = CNT_W'(ENTRIES - 1);

    scan_state_e      state_q, state_d;
    logic [CNT_W-1:0] ptr_q;
    logic             at_last;

    assign at_last  = (ptr_q == LAST_PTR);
    assign rd_ptr_o = ptr_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // slot pointer
    always_ff @(posedge clk) begin
        if (!rst_n)                          ptr_q <= '0;
        else if (state_q == ST_IDLE)         ptr_q <= '0;
        else if (state_q == ST_SCAN && !at_last) ptr_q <= ptr_q + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_SCAN;
            ST_SCAN: if (at_last) state_d = ST_WAIT;
            ST_WAIT: state_d = ST_TAIL;
            ST_TAIL: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o  = 1'b0;
        done_o  = 1'b0;
        rd_en_o = 1'b0;
        load_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_SCAN: begin
                busy_o  = 1'b1;
                rd_en_o = 1'b1;
            end
            ST_WAIT: busy_o = 1'b1;
            ST_TAIL: busy_o = 1'b1;
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/tlbf_match.sv
module tlbf_match
    import tlbf_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int PID_W      = 8,
    parameter int CNT_W      = 7,
    parameter int PAGE_SHIFT = HI_VPN_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [PID_W-1:0]  pid_i,
    input  logic              rd_en_i,
    input  logic [CNT_W-1:0]  rd_ptr_i,
    input  logic [WORD_W-1:0] hi_i,
    input  logic [WORD_W-1:0] lo_i,
    output logic              flush_o,
    output logic [WORD_W-1:0] flush_addr_o,
    output logic [CNT_W-1:0]  flush_ptr_o
);

    logic [PID_W-1:0] pid_q;
    logic             vld_q;
    logic [CNT_W-1:0] ptr_q;
    logic             hit;
    logic             unused_bits;

    assign unused_bits = ^{hi_i[PAGE_SHIFT-1:PID_W],
                           lo_i[WORD_W-1:LO_GLOBAL_BIT+1],
                           lo_i[LO_VALID_BIT-1:0]};

    // captured process tag
    always_ff @(posedge clk) begin
        if (!rst_n)      pid_q <= '0;
        else if (load_i) pid_q <= pid_i;
    end

    // read-latency stage: slot identity travels with its data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            ptr_q <= '0;
        end else begin
            vld_q <= rd_en_i;
            ptr_q <= rd_ptr_i;
        end
    end

    assign hit = vld_q
               && lo_i[LO_VALID_BIT]
               && !lo_i[LO_GLOBAL_BIT]
               && (hi_i[PID_W-1:0] == pid_q);

    // decision stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_o      <= 1'b0;
            flush_addr_o <= '0;
            flush_ptr_o  <= '0;
        end else begin
            flush_o <= hit;
            if (hit) begin
                flush_addr_o <= {hi_i[WORD_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
                flush_ptr_o  <= ptr_q;
            end
        end
    end

endmodule

// File: rtl/tlbf_scanner.sv
module tlbf_scanner
    import tlbf_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int PID_W      = 8,
    parameter int N_TLB      = 2,
    parameter int N_SET      = 4,
    parameter int N_IDX      = 16,
    parameter int PAGE_SHIFT = HI_VPN_LSB,
    parameter int TLB_W      = $clog2(N_TLB),
    parameter int SET_W      = $clog2(N_SET),
    parameter int IDX_W      = $clog2(N_IDX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PID_W-1:0]  pid_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_en_o,
    output logic [TLB_W-1:0]  rd_tlb_o,
    output logic [SET_W-1:0]  rd_set_o,
    output logic [IDX_W-1:0]  rd_idx_o,
    input  logic [WORD_W-1:0] rd_hi_i,
    input  logic [WORD_W-1:0] rd_lo_i,
    output logic              flush_o,
    output logic [WORD_W-1:0] flush_addr_o,
    output logic [TLB_W-1:0]  flush_tlb_o,
    output logic [SET_W-1:0]  flush_set_o,
    output logic [IDX_W-1:0]  flush_idx_o
);

    localparam int ENTRIES = N_TLB * N_SET * N_IDX;
    localparam int CNT_W   = TLB_W + SET_W + IDX_W;

    logic             load;
    logic [CNT_W-1:0] rd_ptr;
    logic [CNT_W-1:0] fl_ptr;

    tlbf_walker #(
        .ENTRIES (ENTRIES),
        .CNT_W   (CNT_W)
    ) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .rd_en_o  (rd_en_o),
        .load_o   (load),
        .rd_ptr_o (rd_ptr)
    );

    tlbf_match #(
        .WORD_W     (WORD_W),
        .PID_W      (PID_W),
        .CNT_W      (CNT_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .pid_i        (pid_i),
        .rd_en_i      (rd_en_o),
        .rd_ptr_i     (rd_ptr),
        .hi_i         (rd_hi_i),
        .lo_i         (rd_lo_i),
        .flush_o      (flush_o),
        .flush_addr_o (flush_addr_o),
        .flush_ptr_o  (fl_ptr)
    );

    // buffer number is the slowest-moving field, slot index the fastest
    assign {rd_tlb_o, rd_set_o, rd_idx_o}          = rd_ptr;
    assign {flush_tlb_o, flush_set_o, flush_idx_o} = fl_ptr;

endmodule

// File: rtl/tlbf_checker.sv
module tlbf_checker #(
    parameter int WORD_W     = 32,
    parameter int PAGE_SHIFT = 13,
    parameter int TLB_W      = 1,
    parameter int SET_W      = 2,
    parameter int IDX_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              rd_en_o,
    input logic [TLB_W-1:0]  rd_tlb_o,
    input logic [SET_W-1:0]  rd_set_o,
    input logic [IDX_W-1:0]  rd_idx_o,
    input logic              flush_o,
    input logic [WORD_W-1:0] flush_addr_o,
    input logic [TLB_W-1:0]  flush_tlb_o,
    input logic [SET_W-1:0]  flush_set_o,
    input logic [IDX_W-1:0]  flush_idx_o
);

    localparam int CW = TLB_W + SET_W + IDX_W;

    logic [CW-1:0] rptr;
    logic [CW-1:0] fptr;
    assign rptr = {rd_tlb_o, rd_set_o, rd_idx_o};
    assign fptr = {flush_tlb_o, flush_set_o, flush_idx_o};

    a_r2_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o && start_i) |=> (busy_o && rd_en_o && rptr == '0));

    a_r3_read_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> busy_o);

    a_r3_read_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o)) |-> (rptr == $past(rptr) + 1'b1));

    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && rd_en_o && rptr != '1) |=> (rd_en_o && rptr == $past(rptr) + 1'b1));

    a_r4_flush_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> ($past(rd_en_o, 2) && fptr == $past(rptr, 2)));

    a_r6_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (flush_addr_o[PAGE_SHIFT-1:0] == '0));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !flush_o && !rd_en_o && $past(busy_o)));

endmodule

bind tlbf_scanner tlbf_checker #(
    .WORD_W     (WORD_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .TLB_W      (TLB_W),
    .SET_W      (SET_W),
    .IDX_W      (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .rd_en_o      (rd_en_o),
    .rd_tlb_o     (rd_tlb_o),
    .rd_set_o     (rd_set_o),
    .rd_idx_o     (rd_idx_o),
    .flush_o      (flush_o),
    .flush_addr_o (flush_addr_o),
    .flush_tlb_o  (flush_tlb_o),
    .flush_set_o  (flush_set_o),
    .flush_idx_o  (flush_idx_o)
);

// File: tb/sim_tlbf_scanner.sv
module sim_tlbf_scanner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  pid_i = 8'h00;
    logic        busy_o, done_o, rd_en_o, flush_o;
    logic [0:0]  rd_tlb_o, flush_tlb_o;
    logic [1:0]  rd_set_o, flush_set_o;
    logic [3:0]  rd_idx_o, flush_idx_o;
    logic [31:0] rd_hi_i = '0, rd_lo_i = '0, flush_addr_o;

    always #4 clk = ~clk;   // 125 MHz

    tlbf_scanner u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pid_i(pid_i),
        .busy_o(busy_o), .done_o(done_o), .rd_en_o(rd_en_o),
        .rd_tlb_o(rd_tlb_o), .rd_set_o(rd_set_o), .rd_idx_o(rd_idx_o),
        .rd_hi_i(rd_hi_i), .rd_lo_i(rd_lo_i), .flush_o(flush_o),
        .flush_addr_o(flush_addr_o), .flush_tlb_o(flush_tlb_o),
        .flush_set_o(flush_set_o), .flush_idx_o(flush_idx_o)
    );

    // storage model: one-cycle read latency
    logic [31:0] hi_mem [128];
    logic [31:0] lo_mem [128];
    always @(posedge clk) begin
        if (rd_en_o) begin
            rd_hi_i <= hi_mem[{rd_tlb_o, rd_set_o, rd_idx_o}];
            rd_lo_i <= lo_mem[{rd_tlb_o, rd_set_o, rd_idx_o}];
        end
    end

    typedef struct {
        logic [31:0] addr;
        int          e;
    } item_t;
    item_t exp_q[$];

    int tests = 0, fails = 0;
    int cyc = 0;
    int v0 = 0;
    int reads = 0;
    int glob_hits = 0;
    bit active = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg;
    endfunction

    // mode 0 mixed, 1 all match, 2 all shared, 3 all invalid
    task automatic fill(input logic [31:0] seed, input logic [7:0] pid, input int mode);
        lcg = seed;
        for (int e = 0; e < 128; e++) begin
            logic [31:0] r1, r2;
            r1 = nxt();
            r2 = nxt();
            hi_mem[e] = {r1[31:13], 5'b0, (r2[20] ? pid : r2[15:8])};
            lo_mem[e] = r2;
            if (mode == 1 || (mode == 0 && (e == 0 || e == 127))) begin
                hi_mem[e][7:0] = pid;
                lo_mem[e][3]   = 1'b1;
                lo_mem[e][4]   = 1'b0;
            end else if (mode == 2) begin
                hi_mem[e][7:0] = pid;
                lo_mem[e][3]   = 1'b1;
                lo_mem[e][4]   = 1'b1;
            end else if (mode == 3) begin
                hi_mem[e][7:0] = pid;
                lo_mem[e][3]   = 1'b0;
            end
        end
    endtask

    // monitor: compares flushes and read addresses against expectations
    always @(negedge clk) begin
        if (active) begin
            if (rd_en_o) begin
                reads++;
                chk({rd_tlb_o, rd_set_o, rd_idx_o} == 7'(cyc - v0), "R3 read address",
                    32'({rd_tlb_o, rd_set_o, rd_idx_o}), 32'(cyc - v0));
            end
            if (flush_o) begin
                if (lo_mem[{flush_tlb_o, flush_set_o, flush_idx_o}][4]) glob_hits++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected flush", 32'({flush_tlb_o, flush_set_o, flush_idx_o}), 32'hFFFF_FFFF);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(flush_addr_o == it.addr, "R6 flush address", flush_addr_o, it.addr);
                    chk({flush_tlb_o, flush_set_o, flush_idx_o} == 7'(it.e), "R5 flushed slot",
                        32'({flush_tlb_o, flush_set_o, flush_idx_o}), 32'(it.e));
                    chk(cyc == v0 + it.e + 2, "R4 flush timing", 32'(cyc - v0), 32'(it.e + 2));
                end
            end
        end
    end

    task automatic run_walk(input logic [7:0] pid);
        for (int e = 0; e < 128; e++) begin
            if (lo_mem[e][3] && !lo_mem[e][4] && hi_mem[e][7:0] == pid) begin
                item_t it;
                it.addr = {hi_mem[e][31:13], 13'b0};
                it.e = e;
                exp_q.push_back(it);
            end
        end
        reads = 0;
        glob_hits = 0;
        @(negedge clk);
        chk(!busy_o && !done_o, "R10 idle before start", {30'b0, busy_o, done_o}, 32'h0);
        start_i = 1'b1;
        pid_i = pid;
        v0 = cyc + 1;
        active = 1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && rd_en_o, "R2 walk begins", {30'b0, busy_o, rd_en_o}, 32'h3);
        // restart attempt with another tag mid-walk
        repeat (40) @(negedge clk);
        start_i = 1'b1;
        pid_i = ~pid;
        @(negedge clk);
        start_i = 1'b0;
        while (cyc != v0 + 129) @(negedge clk);
        chk(busy_o && !done_o, "R8 busy through last cycle", {30'b0, busy_o, done_o}, 32'h2);
        @(negedge clk);
        chk(done_o && !busy_o, "R8 done pulse", {30'b0, busy_o, done_o}, 32'h1);
        start_i = 1'b1;         // request during completion cycle
        @(negedge clk);
        start_i = 1'b0;
        chk(!done_o && !busy_o, "R9 start in done ignored", {30'b0, busy_o, done_o}, 32'h0);
        @(negedge clk);
        chk(!busy_o && !rd_en_o, "R9 still idle", {30'b0, busy_o, rd_en_o}, 32'h0);
        active = 0;
        chk(reads == 128, "R3 read count", 32'(reads), 32'd128);
        chk(exp_q.size() == 0, "R6 all expected flushes seen", 32'(exp_q.size()), 32'd0);
        chk(glob_hits == 0, "R7 shared slots kept", 32'(glob_hits), 32'd0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !rd_en_o && !flush_o, "R1 reset state",
            {28'b0, busy_o, done_o, rd_en_o, flush_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !rd_en_o && !flush_o, "R1 after release",
            {28'b0, busy_o, done_o, rd_en_o, flush_o}, 32'h0);
        fill(32'hA5A5_0001, 8'h5A, 0); run_walk(8'h5A);
        fill(32'h0BAD_F00D, 8'h00, 0); run_walk(8'h00);
        fill(32'h7777_1357, 8'hFF, 1); run_walk(8'hFF);   // R10 back-to-back, every slot flushed
        fill(32'h3141_5926, 8'h21, 2); run_walk(8'h21);   // R7 all shared
        fill(32'h2718_2818, 8'h99, 3); run_walk(8'h99);   // R7 all invalid
        fill(32'hC0DE_CAFE, 8'h3C, 0); run_walk(8'h3C);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule